// File: doc/BRIEF.md
# Comparator Output Conditioning Channel

This block cleans up one channel of an analog comparator result before the rest of the chip uses it. The comparator bit arrives with no timing relation to the peripheral clock. The block brings it into the clock domain and can flip its sense. A glitch filter then passes a new level only after it has stayed stable for a programmable number of clock samples.

The cleaned level feeds an edge detector. It raises a one-cycle interrupt pulse, and optionally a wake pulse, on rising edges, falling edges or both. Output gating chooses whether the external pin sees the quick unfiltered level or the filtered one. It also provides a status bit that software can read. All control inputs are held steady by a register block outside this module.

Top module: `cmp_cond_chan`

## Requirements
- R1: While `en_i` is 0, `status_o` and `pin_o` are 0. No `irq_o` or `wake_o` pulse appears in the cycle after any cycle with `en_i` at 0. All four outputs are 0 during reset.
- R2: The comparator bit passes through two clock flops. With the filter bypassed (`filt_sel_i` = 0), a level change on `cmp_raw_i` reaches `status_o` after exactly two rising clock edges.
- R3: With `inv_i` at 1, the synchronised bit is inverted before filtering, edge detection and pin selection.
- R4: For `filt_sel_i` = c in 1..7, the filtered level changes only after the new level has been sampled on 2^(c-1) consecutive edges (1, 2, 4, 8, 16, 32, 64). A step on `cmp_raw_i` therefore reaches `status_o` after 2 + 2^(c-1) edges.
- R5: A pulse on the conditioned bit that lasts fewer samples than the selected count leaves `status_o` unchanged and raises no interrupt. A pulse of exactly that many samples is passed.
- R6: A change of `filt_sel_i` restarts the stability count from zero. The filtered level keeps its value until the new count is met.
- R7: `edge_sel_i` = 0 flags both edges, 1 flags rising edges only, and 2 flags falling edges only. The edges are taken on the filtered level.
- R8: `edge_sel_i` = 3 raises no event on any edge.
- R9: An event produces a one-cycle `irq_o` pulse only when `irq_en_i` is 1. The pulse comes one edge after the filtered level changes, which is three edges after a bypassed raw step.
- R10: `wake_o` pulses together with `irq_o` only when both `irq_en_i` and `wake_en_i` are 1.
- R11: With `out_src_i` = 0, `pin_o` carries the unfiltered conditioned bit. With `out_src_i` = 1 it carries the filtered level.
- R12: Disabling the channel clears the filter and the edge history to 0. A low level present when the channel is enabled again is not reported as a falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw_i | input | 1 | Comparator result, asynchronous to clk |
| en_i | input | 1 | Channel enable |
| inv_i | input | 1 | Invert the comparator sense |
| filt_sel_i | input | 3 | Filter length code: 0 bypass, c gives 2^(c-1) samples |
| out_src_i | input | 1 | Pin source: 0 unfiltered, 1 filtered |
| edge_sel_i | input | 2 | Edge type: 0 both, 1 rising, 2 falling, 3 none |
| irq_en_i | input | 1 | Interrupt enable |
| wake_en_i | input | 1 | Wake enable, qualified by interrupt enable |
| pin_o | output | 1 | Selected level for the output pin |
| status_o | output | 1 | Filtered level for software, 0 when disabled |
| irq_o | output | 1 | One-cycle interrupt event pulse |
| wake_o | output | 1 | One-cycle wake event pulse |

## Verification
The properties assume that the control fields are quasi-static. They change only between cycles, driven from register flops, so a one-cycle history of the filtered level means something. The comparator bit is treated as fully asynchronous, and no property depends on its timing. The stimulus therefore changes controls and the raw bit only on falling clock edges. It lets the filter settle fully after each change of `filt_sel_i` before measuring a latency. The exception is the test that changes the filter length while a count is running.

// File: rtl/cmpc_pkg.sv
package cmpc_pkg;

    // Edge qualification codes; the encoding is visible at the edge_sel_i port.
    typedef enum logic [1:0] {
        EDGE_BOTH = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_RSVD = 2'd3
    } edge_mode_e;

    // Registered state of the edge detector.
    typedef struct packed {
        logic hist;
        logic irq;
        logic wake;
    } edge_state_t;

endpackage

// File: rtl/cmpc_sync.sv
// Multi-flop synchroniser for one asynchronous bit.
module cmpc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign chain_d[i] = d_i;
        end else begin : g_next
            assign chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/cmpc_filter.sv
// Consecutive-sample glitch filter with a power-of-two length select.
module cmpc_filter #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             d_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             filt_o
);

    localparam int MAX_EXP = (1 << SEL_W) - 2;
    localparam int CNT_W   = MAX_EXP + 1;

    typedef struct packed {
        logic             level;
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
    } filt_state_t;

    filt_state_t st_d, st_q;
    logic [CNT_W-1:0] need;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        need    = '0;
        if (sel_i != '0) need = CNT_W'(1) << (sel_i - SEL_W'(1));
        cnt_inc = st_q.cnt + CNT_W'(1);
        st_d     = st_q;
        st_d.sel = sel_i;
        if (!en_i) begin
            st_d.level = 1'b0;
            st_d.cnt   = '0;
        end else if (sel_i != st_q.sel) begin
            // new length: restart the count, hold the level
            st_d.cnt = '0;
        end else if (sel_i == '0) begin
            st_d.level = d_i;
            st_d.cnt   = '0;
        end else if (d_i == st_q.level) begin
            st_d.cnt = '0;
        end else if (cnt_inc >= need) begin
            st_d.level = d_i;
            st_d.cnt   = '0;
        end else begin
            st_d.cnt = cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt_o = (sel_i == '0) ? d_i : st_q.level;

endmodule

// File: rtl/cmpc_edge.sv
// Edge detector on the filtered level with registered event pulses.
module cmpc_edge
    import cmpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       lvl_i,
    input  edge_mode_e mode_i,
    input  logic       irq_en_i,
    input  logic       wake_en_i,
    output logic       irq_o,
    output logic       wake_o
);

    edge_state_t st_d, st_q;
    logic rise, fall, hit;

    always_comb begin
        rise = en_i &  lvl_i & ~st_q.hist;
        fall = en_i & ~lvl_i &  st_q.hist;
        unique case (mode_i)
            EDGE_BOTH: hit = rise | fall;
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            default:   hit = 1'b0;
        endcase
        st_d.hist = en_i & lvl_i;
        st_d.irq  = hit & irq_en_i;
        st_d.wake = hit & irq_en_i & wake_en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o  = st_q.irq;
    assign wake_o = st_q.wake;

endmodule

// File: rtl/cmp_cond_chan.sv
// One comparator conditioning channel: sync, invert, filter, edge events.
module cmp_cond_chan
    import cmpc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FSEL_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_raw_i,
    input  logic              en_i,
    input  logic              inv_i,
    input  logic [FSEL_W-1:0] filt_sel_i,
    input  logic              out_src_i,
    input  logic [1:0]        edge_sel_i,
    input  logic              irq_en_i,
    input  logic              wake_en_i,
    output logic              pin_o,
    output logic              status_o,
    output logic              irq_o,
    output logic              wake_o
);

    logic sync_bit;
    logic cond_bit;
    logic filt_bit;

    cmpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cmp_raw_i),
        .q_o   (sync_bit)
    );

    assign cond_bit = sync_bit ^ inv_i;

    cmpc_filter #(.SEL_W(FSEL_W)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .d_i    (cond_bit),
        .sel_i  (filt_sel_i),
        .filt_o (filt_bit)
    );

    cmpc_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .lvl_i     (filt_bit),
        .mode_i    (edge_mode_e'(edge_sel_i)),
        .irq_en_i  (irq_en_i),
        .wake_en_i (wake_en_i),
        .irq_o     (irq_o),
        .wake_o    (wake_o)
    );

    assign status_o = en_i & filt_bit;
    assign pin_o    = en_i & (out_src_i ? filt_bit : cond_bit);

endmodule

// File: rtl/cmp_cond_chan_chk.sv
// Property checker attached to the conditioning channel.
module cmp_cond_chan_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_i,
    input logic [1:0] edge_sel_i,
    input logic       status_o,
    input logic       irq_o,
    input logic       wake_o
);

    // R1
    off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!irq_o && !wake_o));

    // R10
    wake_within_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> irq_o);

    // R8
    reserved_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel_i == 2'b11) |=> !irq_o);

    // R7
    rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel_i == 2'b01 && !status_o) |=> !irq_o);

    // R7
    fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel_i == 2'b10 && en_i && status_o) |=> !irq_o);

    // R9
    irq_follows_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(status_o) != $past(status_o, 2)));

endmodule

bind cmp_cond_chan cmp_cond_chan_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .edge_sel_i (edge_sel_i),
    .status_o   (status_o),
    .irq_o      (irq_o),
    .wake_o     (wake_o)
);

// File: tb/cmp_cond_chan_tb.sv
`timescale 1ns/1ps
module cmp_cond_chan_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_raw_i = 1'b0;
    logic       en_i = 1'b0;
    logic       inv_i = 1'b0;
    logic [2:0] filt_sel_i = 3'd0;
    logic       out_src_i = 1'b0;
    logic [1:0] edge_sel_i = 2'd0;
    logic       irq_en_i = 1'b0;
    logic       wake_en_i = 1'b0;
    logic       pin_o, status_o, irq_o, wake_o;

    int n_chk = 0;
    int n_bad = 0;
    int irq_seen = 0;
    int wake_seen = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cmp_cond_chan u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_raw_i  (cmp_raw_i),
        .en_i       (en_i),
        .inv_i      (inv_i),
        .filt_sel_i (filt_sel_i),
        .out_src_i  (out_src_i),
        .edge_sel_i (edge_sel_i),
        .irq_en_i   (irq_en_i),
        .wake_en_i  (wake_en_i),
        .pin_o      (pin_o),
        .status_o   (status_o),
        .irq_o      (irq_o),
        .wake_o     (wake_o)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            irq_seen  <= irq_seen + int'(irq_o);
            wake_seen <= wake_seen + int'(wake_o);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_counts();
        irq_seen  = 0;
        wake_seen = 0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Steps until status_o reaches want, returning the number of edges.
    task automatic measure(input logic want, output int lat);
        lat = 0;
        while (status_o !== want && lat < 300) begin
            step(1);
            lat++;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            finish_run();
        end
    end

    initial begin
        int lat;
        int exp_lat;
        int hi_cnt;

        // R1 reset state
        step(3);
        chk("R1 reset status", int'(status_o), 0);
        chk("R1 reset pin", int'(pin_o), 0);
        chk("R1 reset irq", int'(irq_o), 0);
        chk("R1 reset wake", int'(wake_o), 0);
        rst_n = 1'b1;
        step(2);

        // R1 disabled channel ignores activity
        irq_en_i = 1'b1; wake_en_i = 1'b1; out_src_i = 1'b0;
        clr_counts();
        for (int k = 0; k < 6; k++) begin
            cmp_raw_i = ~cmp_raw_i;
            step(3);
            chk("R1 disabled status", int'(status_o), 0);
            chk("R1 disabled pin", int'(pin_o), 0);
        end
        cmp_raw_i = 1'b0;
        step(4);
        chk("R1 disabled irq count", irq_seen, 0);
        chk("R1 disabled wake count", wake_seen, 0);

        // R2 R4 latency sweep over every filter code, both directions
        en_i = 1'b1; wake_en_i = 1'b0; edge_sel_i = 2'd0;
        for (int c = 0; c < 8; c++) begin
            filt_sel_i = 3'(c);
            step(80);
            exp_lat = (c == 0) ? 2 : 2 + (1 << (c - 1));
            clr_counts();
            cmp_raw_i = 1'b1;
            measure(1'b1, lat);
            chk((c == 0) ? "R2 bypass rise latency" : "R4 filtered rise latency", lat, exp_lat);
            step(4);
            chk("R7 both-edge rise count", irq_seen, 1);
            clr_counts();
            cmp_raw_i = 1'b0;
            measure(1'b0, lat);
            chk((c == 0) ? "R2 bypass fall latency" : "R4 filtered fall latency", lat, exp_lat);
            step(4);
            chk("R7 both-edge fall count", irq_seen, 1);
        end

        // R7 R8 edge mode sweep, filter bypassed
        filt_sel_i = 3'd0;
        for (int m = 0; m < 4; m++) begin
            edge_sel_i = 2'(m);
            step(6);
            clr_counts();
            cmp_raw_i = 1'b1;
            step(6);
            chk((m == 3) ? "R8 reserved rise" : "R7 rise events", irq_seen,
                (m == 0 || m == 1) ? 1 : 0);
            clr_counts();
            cmp_raw_i = 1'b0;
            step(6);
            chk((m == 3) ? "R8 reserved fall" : "R7 fall events", irq_seen,
                (m == 0 || m == 2) ? 1 : 0);
        end

        // R9 R10 enable combinations and pulse timing
        edge_sel_i = 2'd0;
        for (int e = 0; e < 4; e++) begin
            irq_en_i  = e[0];
            wake_en_i = e[1];
            step(4);
            clr_counts();
            cmp_raw_i = 1'b1;
            step(2);
            chk("R9 irq low before event", int'(irq_o), 0);
            step(1);
            chk("R9 irq at third edge", int'(irq_o), int'(e[0]));
            chk("R10 wake at third edge", int'(wake_o), int'(e[0] & e[1]));
            step(1);
            chk("R9 irq single cycle", int'(irq_o), 0);
            step(3);
            chk("R9 irq pulse count", irq_seen, int'(e[0]));
            chk("R10 wake pulse count", wake_seen, int'(e[0] & e[1]));
            cmp_raw_i = 1'b0;
            step(6);
        end
        irq_en_i = 1'b1; wake_en_i = 1'b0;

        // R3 inversion
        inv_i = 1'b1;
        step(3);
        chk("R3 inverted low gives status", int'(status_o), 1);
        chk("R3 inverted low gives pin", int'(pin_o), 1);
        cmp_raw_i = 1'b1;
        step(2);
        chk("R3 inverted high gives status", int'(status_o), 0);
        inv_i = 1'b0;
        step(3);
        chk("R3 inversion removed", int'(status_o), 1);
        cmp_raw_i = 1'b0;
        step(4);

        // R11 pin source selection with the longest filter
        filt_sel_i = 3'd7;
        out_src_i  = 1'b0;
        step(80);
        cmp_raw_i = 1'b1;
        step(3);
        chk("R11 raw pin follows quickly", int'(pin_o), 1);
        chk("R11 status still filtered", int'(status_o), 0);
        out_src_i = 1'b1;
        step(1);
        chk("R11 filtered pin held low", int'(pin_o), 0);
        step(70);
        chk("R11 filtered pin after count", int'(pin_o), 1);
        cmp_raw_i = 1'b0;
        step(80);
        chk("R11 filtered pin returns low", int'(pin_o), 0);
        out_src_i = 1'b0;

        // R5 glitch rejection at the count boundary (8 samples)
        filt_sel_i = 3'd4;
        step(20);
        clr_counts();
        hi_cnt = 0;
        cmp_raw_i = 1'b1;
        for (int k = 0; k < 7; k++) begin
            step(1);
            hi_cnt += int'(status_o);
        end
        cmp_raw_i = 1'b0;
        for (int k = 0; k < 20; k++) begin
            step(1);
            hi_cnt += int'(status_o);
        end
        chk("R5 short pulse rejected", hi_cnt, 0);
        chk("R5 short pulse no irq", irq_seen, 0);
        hi_cnt = 0;
        cmp_raw_i = 1'b1;
        for (int k = 0; k < 8; k++) begin
            step(1);
            hi_cnt += int'(status_o);
        end
        cmp_raw_i = 1'b0;
        for (int k = 0; k < 20; k++) begin
            step(1);
            hi_cnt += int'(status_o);
        end
        chk("R5 full-length pulse passed", int'(hi_cnt > 0), 1);
        step(20);

        // R6 filter select change restarts the count
        filt_sel_i = 3'd5;
        step(40);
        cmp_raw_i = 1'b1;
        step(10);
        filt_sel_i = 3'd6;
        measure(1'b1, lat);
        chk("R6 count restarted after select change", lat, 33);
        cmp_raw_i = 1'b0;
        step(80);

        // R12 history cleared while disabled
        filt_sel_i = 3'd0;
        edge_sel_i = 2'd2;
        cmp_raw_i  = 1'b1;
        step(6);
        chk("R12 enabled high level", int'(status_o), 1);
        clr_counts();
        en_i = 1'b0;
        step(1);
        chk("R1 status cleared on disable", int'(status_o), 0);
        cmp_raw_i = 1'b0;
        step(5);
        en_i = 1'b1;
        step(6);
        chk("R12 no falling event on re-enable", irq_seen, 0);
        edge_sel_i = 2'd0;
        cmp_raw_i  = 1'b1;
        step(6);
        chk("R12 channel live after re-enable", irq_seen, 1);

        done = 1'b1;
        finish_run();
    end

endmodule